// File: doc/BRIEF.md
# USB IN Endpoint Status Controller

This block holds the control and status logic for a single bulk IN endpoint of a USB device controller. It sits between a CPU register port and the endpoint's protocol engine. It watches the transmit FIFO fill level and raises a DMA fill request whenever the FIFO is running low. It records packet completion together with that packet's outcome: a missing host ACK and a FIFO underrun. It records that a STALL handshake was sent, and it raises a transmit interrupt.

For every IN token it chooses the handshake the protocol engine should return: data, NAK or STALL. Once a packet has completed, the endpoint answers NAK until software acknowledges the completion. Software can also force STALL answers. The 8-bit status word is read combinationally. Writes take effect at the next clock edge.

Top module: `usb_in_ep_ctl`

## Requirements
- R1: After reset, every status flag, the force-stall bit, `tx_irq` and `hs_valid` are 0.
- R2: Bit 0 of `reg_rdata` and `dma_req` are both 1 when `fifo_level` is at most `SVC_THRESH` (default 8) and 0 when it is above. They follow `fifo_level` combinationally.
- R3: The `reg_rdata` layout is: bit 0 FIFO service, bit 1 packet complete, bit 2 packet error, bit 3 underrun, bit 4 sent stall, bit 5 force stall. Bits 7:6 always read 0.
- R4: A `pkt_done` pulse sets packet complete at the next edge. Packet complete clears only when a write has bit 1 equal to 1. A write with bit 1 equal to 0 leaves it set.
- R5: The cycle after an `in_token` pulse, `hs_valid` is 1 and `hs_code` gives the answer: 2'b11 STALL when force stall is set, otherwise 2'b10 NAK when packet complete is set, otherwise 2'b01 data. The decision uses the state held before the token's edge. In other cycles `hs_valid` is 0.
- R6: On `pkt_done`, packet error takes the value of `pkt_nack`. Underrun is set by a `pkt_underrun` pulse at any time. Both flags clear when packet complete is cleared, unless an underrun pulse arrives in the same cycle as the clear.
- R7: A `stall_sent` pulse sets sent stall. Sent stall clears only on a write with bit 4 equal to 1. If the pulse and the clear come together, the set wins.
- R8: Force stall (bit 5) is loaded from `reg_wdata[5]` on every write.
- R9: `tx_irq` sets when `pkt_done` arrives while `tx_int_en` is 1. It stays low if `tx_int_en` is 0. It clears when packet complete is cleared by software.
- R10: When `pkt_done` and a clear of packet complete arrive in the same cycle, packet complete stays set, packet error takes the new value, and `tx_irq` is not cleared.
- R11: Write data in bits 0, 2, 3, 6 and 7 has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LW | Bytes currently in the transmit FIFO |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read data |
| tx_int_en | input | 1 | Transmit interrupt enable |
| pkt_done | input | 1 | Pulse: a packet was fully sent |
| pkt_nack | input | 1 | With `pkt_done`: the host gave no ACK |
| pkt_underrun | input | 1 | Pulse: the FIFO ran dry mid-packet |
| stall_sent | input | 1 | Pulse: a STALL handshake went out |
| in_token | input | 1 | Pulse: an IN token was received |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 01 data, 10 NAK, 11 STALL |
| dma_req | output | 1 | DMA FIFO fill request |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The risky overlap is a packet completing in the same cycle that software writes 1 to clear the previous completion. The bench provokes this by driving `pkt_done` (with `pkt_nack` high) together with a clearing write. It judges the result by checking that packet complete, packet error and `tx_irq` all remain set, and then that a following IN token is answered with NAK. A second overlap pairs a `stall_sent` pulse with a write that clears sent stall; here the flag must stay 1.

// File: rtl/usb_in_ep_ctl.sv
module usb_in_ep_ctl #(
  parameter int DEPTH      = 16,
  parameter int SVC_THRESH = 8,
  parameter int LW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] fifo_level,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          tx_int_en,
  input  logic          pkt_done,
  input  logic          pkt_nack,
  input  logic          pkt_underrun,
  input  logic          stall_sent,
  input  logic          in_token,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          dma_req,
  output logic          tx_irq
);
  localparam logic [1:0] HS_DATA  = 2'b01;
  localparam logic [1:0] HS_NAK   = 2'b10;
  localparam logic [1:0] HS_STALL = 2'b11;

  logic cplt_q, err_q, urun_q, sst_q, fst_q, irq_q, hsv_q;
  logic [1:0] hsc_q;
  logic svc, clr_cplt, clr_sst;

  assign svc      = (32'(fifo_level) <= SVC_THRESH);
  assign clr_cplt = reg_wr & reg_wdata[1];
  assign clr_sst  = reg_wr & reg_wdata[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cplt_q <= 1'b0;
      err_q  <= 1'b0;
      urun_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (pkt_done) begin
      cplt_q <= 1'b1;
      err_q  <= pkt_nack;
      urun_q <= urun_q | pkt_underrun;
      irq_q  <= irq_q | tx_int_en;
    end else if (clr_cplt) begin
      cplt_q <= 1'b0;
      err_q  <= 1'b0;
      urun_q <= pkt_underrun;
      irq_q  <= 1'b0;
    end else if (pkt_underrun) begin
      urun_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sst_q <= 1'b0;
      fst_q <= 1'b0;
    end else begin
      if (stall_sent)   sst_q <= 1'b1;
      else if (clr_sst) sst_q <= 1'b0;
      if (reg_wr)       fst_q <= reg_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsv_q <= 1'b0;
      hsc_q <= 2'b00;
    end else begin
      hsv_q <= in_token;
      if (in_token)
        hsc_q <= fst_q ? HS_STALL : (cplt_q ? HS_NAK : HS_DATA);
    end
  end

  assign reg_rdata = {2'b00, fst_q, sst_q, urun_q, err_q, cplt_q, svc};
  assign dma_req   = svc;
  assign tx_irq    = irq_q;
  assign hs_valid  = hsv_q;
  assign hs_code   = hsc_q;

  p_done_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> reg_rdata[1]);
  p_stall_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && reg_rdata[5]) |=> (hs_valid && hs_code == 2'b11));
  p_nak_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !reg_rdata[5] && reg_rdata[1]) |=> (hs_valid && hs_code == 2'b10));
  p_err_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !pkt_done && reg_wr && reg_wdata[1]) |=> (!reg_rdata[1] && !reg_rdata[2]));
  p_sst_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent |=> reg_rdata[4]);
  p_irq_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && tx_int_en) |=> tx_irq);
endmodule

// File: tb/usb_in_ep_ctl_tb.sv
module usb_in_ep_ctl_tb;
  localparam int LW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] fifo_level = '0;
  logic reg_wr = 0, tx_int_en = 0, pkt_done = 0, pkt_nack = 0, pkt_underrun = 0;
  logic stall_sent = 0, in_token = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic hs_valid, dma_req, tx_irq;
  logic [1:0] hs_code;
  int total = 0, bad = 0;
  bit done = 0;

  usb_in_ep_ctl u_dut (.clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_int_en(tx_int_en), .pkt_done(pkt_done),
    .pkt_nack(pkt_nack), .pkt_underrun(pkt_underrun), .stall_sent(stall_sent),
    .in_token(in_token), .hs_valid(hs_valid), .hs_code(hs_code), .dma_req(dma_req),
    .tx_irq(tx_irq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    reg_wr = 0; reg_wdata = '0; pkt_done = 0; pkt_nack = 0; pkt_underrun = 0;
    stall_sent = 0; in_token = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; step();
  endtask

  task automatic token(input logic [1:0] exp, input string req);
    in_token = 1; step();
    chk({req, " hs_valid"}, hs_valid, 1);
    chk({req, " hs_code"}, hs_code, exp);
    step();
    chk({req, " hs_valid drop"}, hs_valid, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  task automatic t_reset();
    fifo_level = 5'd20;
    do_reset();
    chk("R1 status", reg_rdata, 8'h00);
    chk("R1 irq", tx_irq, 0);
    chk("R1 hs_valid", hs_valid, 0);
  endtask

  task automatic t_fifo();
    fifo_level = 5'd9;  #1; chk("R2 level9 dma", dma_req, 0); chk("R2 level9 bit0", reg_rdata[0], 0);
    fifo_level = 5'd8;  #1; chk("R2 level8 dma", dma_req, 1); chk("R2 level8 bit0", reg_rdata[0], 1);
    fifo_level = 5'd0;  #1; chk("R2 empty", dma_req, 1);
    fifo_level = 5'd16; #1; chk("R2 full", dma_req, 0);
  endtask

  task automatic t_complete();
    token(2'b01, "R5 idle data");
    pkt_done = 1; step();
    chk("R4 set", reg_rdata, 8'h02);
    wr(8'h00);
    chk("R4 write0 keeps", reg_rdata[1], 1);
    token(2'b10, "R5 nak while complete");
    wr(8'h02);
    chk("R4 cleared", reg_rdata[1], 0);
    token(2'b01, "R5 data after clear");
  endtask

  task automatic t_errors();
    pkt_underrun = 1; step();
    pkt_done = 1; pkt_nack = 1; step();
    chk("R6 err+urun", reg_rdata, 8'h0E);
    chk("R3 reserved zero", reg_rdata[7:6], 0);
    wr(8'h02);
    chk("R6 cleared with complete", reg_rdata, 8'h00);
    pkt_done = 1; step();
    chk("R6 acked no err", reg_rdata, 8'h02);
    wr(8'h02);
  endtask

  task automatic t_sst();
    stall_sent = 1; step();
    chk("R7 set", reg_rdata, 8'h10);
    wr(8'h00); chk("R7 write0 keeps", reg_rdata[4], 1);
    stall_sent = 1; reg_wr = 1; reg_wdata = 8'h10; step();
    chk("R7 set beats clear", reg_rdata[4], 1);
    wr(8'h10); chk("R7 cleared", reg_rdata[4], 0);
  endtask

  task automatic t_force();
    wr(8'h20); chk("R8 set", reg_rdata, 8'h20);
    token(2'b11, "R5 stall forced");
    pkt_done = 1; reg_wr = 1; reg_wdata = 8'h20; step();
    token(2'b11, "R5 stall over nak");
    wr(8'h02); chk("R8 cleared by write", reg_rdata, 8'h00);
  endtask

  task automatic t_irq();
    pkt_done = 1; step();
    chk("R9 disabled no irq", tx_irq, 0);
    wr(8'h02);
    tx_int_en = 1; pkt_done = 1; step();
    chk("R9 irq set", tx_irq, 1);
    wr(8'h02); chk("R9 irq cleared", tx_irq, 0);
  endtask

  task automatic t_collide();
    pkt_done = 1; step();
    pkt_done = 1; pkt_nack = 1; reg_wr = 1; reg_wdata = 8'h02; step();
    chk("R10 complete+err kept", reg_rdata, 8'h06);
    chk("R10 irq kept", tx_irq, 1);
    token(2'b10, "R10 still naks");
    wr(8'h02);
    tx_int_en = 0;
  endtask

  task automatic t_ignored();
    pkt_done = 1; pkt_underrun = 1; step();
    wr(8'hCD);
    chk("R11 ignored bits", reg_rdata, 8'h0A);
    wr(8'h02);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset(); t_fifo(); t_complete(); t_errors(); t_sst();
    t_force(); t_irq(); t_collide(); t_ignored();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule